// File: doc/BRIEF.md
# Floating-Point Error Report Steering

The block decides where a pending, unmasked floating-point error goes once the FPU flags it. Software picks one of two reporting schemes through a single bit of a control word. In native mode the error is held pending. The core then receives a one-cycle exception request at the moment the next waiting FP instruction (or a WAIT-type instruction) tries to issue. In legacy mode the error is reported through an active-low pin meant for an outside interrupt controller, unless an external ignore input is asserted, in which case the error is dropped.

While a legacy error is reported on the pin, the block stalls issue, but only in front of waiting FP or WAIT-type instructions. Instructions that do not wait, and non-FP instructions, keep flowing. The pending state, in either mode, ends only when the core pulses an explicit clear input. The ignore input comes from outside the clock domain and passes through a synchronizer before the block uses it.

Top module: `fpuErrReport`

## Requirements
- R1: While reset is asserted and in the first cycle after it, errPinN is 1, nativeExcReq is 0 and issueStall is 0.
- R2: An errStrobe taken with native mode selected leaves errPinN at 1 and never stalls. nativeExcReq is 1 for exactly one cycle, which is the first later cycle in which issueValid and issueWaitClass are both 1.
- R3: An errStrobe taken in legacy mode while the synchronized ignore value is 1 is dropped. errPinN stays 1, and nativeExcReq and issueStall stay 0.
- R4: An errStrobe taken in legacy mode while the synchronized ignore value is 0 drives errPinN to 0 from the cycle after the strobe edge.
- R5: While errPinN is 0, issueStall equals issueValid AND issueWaitClass, so non-waiting and non-FP instructions (issueWaitClass = 0) are not stalled.
- R6: errPinN, once 0, stays 0 until an edge with errClear = 1, and it returns to 1 in the cycle after that edge.
- R7: ignoreErrAsync reaches the decision through two flops. An errStrobe at the first or second edge after a change of ignoreErrAsync is judged by the previous ignore value.
- R8: When errStrobe and errClear are both 1 at the same edge, the new error wins and the block stays pending.
- R9: errClear also discards a pending native error, so no exception request follows it.
- R10: Native mode is selected when bit 5 of ctrlWord is 1 and legacy mode when it is 0. All other ctrlWord bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWord | input | 32 | Control word; bit 5 selects native reporting |
| ignoreErrAsync | input | 1 | Asynchronous ignore-error request, active high |
| errStrobe | input | 1 | One-cycle pulse: unmasked FP error detected |
| errClear | input | 1 | Explicit clear of the pending error |
| issueValid | input | 1 | An instruction is presented for issue |
| issueWaitClass | input | 1 | That instruction is a waiting FP or WAIT-type instruction |
| nativeExcReq | output | 1 | One-cycle native exception request |
| errPinN | output | 1 | External error pin, active low |
| issueStall | output | 1 | Hold issue of the presented instruction |

## Verification
Two functions can land on the same edge: a fresh error strobe and the clear of the previous one. A native request can also fire on the same edge that a new native strobe arrives. The bench drives each collision on purpose and also lets a long random stretch produce them by chance. A behavioural model applies the rule that the new error takes precedence and compares all three outputs on every cycle. A strobe placed one edge after an ignore change checks that the synchronizer delay is honoured.

// File: rtl/fpuErrPkg.sv
package fpuErrPkg;
  typedef struct packed {
    logic setNative;
    logic clrNative;
    logic setLegacy;
    logic clrLegacy;
  } errStrobes_t;
endpackage

// File: rtl/fpuErrSync.sv
module fpuErrSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/fpuErrCtrl.sv
module fpuErrCtrl
  import fpuErrPkg::*;
(
  input  logic        nativeEn,
  input  logic        ignSync,
  input  logic        errStrobe,
  input  logic        errClear,
  input  logic        issueValid,
  input  logic        issueWaitClass,
  input  logic        nativePend,
  input  logic        legacyPend,
  output errStrobes_t stb,
  output logic        nativeExcReq,
  output logic        issueStall
);
  logic waitIssue;

  always_comb begin
    waitIssue     = issueValid & issueWaitClass;
    nativeExcReq  = nativePend & waitIssue;
    issueStall    = legacyPend & waitIssue;
    stb.setNative = errStrobe & nativeEn;
    stb.setLegacy = errStrobe & ~nativeEn & ~ignSync;
    stb.clrNative = errClear | nativeExcReq;
    stb.clrLegacy = errClear;
  end
endmodule

// File: rtl/fpuErrDp.sv
module fpuErrDp
  import fpuErrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  errStrobes_t stb,
  output logic        nativePend,
  output logic        legacyPend,
  output logic        errPinN
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nativePend <= 1'b0;
      legacyPend <= 1'b0;
    end else begin
      if (stb.setNative)      nativePend <= 1'b1;
      else if (stb.clrNative) nativePend <= 1'b0;
      if (stb.setLegacy)      legacyPend <= 1'b1;
      else if (stb.clrLegacy) legacyPend <= 1'b0;
    end
  end

  assign errPinN = ~legacyPend;

  // R8
  new_err_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setLegacy |=> legacyPend);
endmodule

// File: rtl/fpuErrReport.sv
module fpuErrReport
  import fpuErrPkg::*;
#(
  parameter int CTRL_W      = 32,
  parameter int NE_BIT      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              ignoreErrAsync,
  input  logic              errStrobe,
  input  logic              errClear,
  input  logic              issueValid,
  input  logic              issueWaitClass,
  output logic              nativeExcReq,
  output logic              errPinN,
  output logic              issueStall
);
  logic        nativeEn;
  logic        ignSync;
  logic        nativePend;
  logic        legacyPend;
  errStrobes_t stb;
  logic        unusedCtrl;

  assign nativeEn   = ctrlWord[NE_BIT];
  assign unusedCtrl = ^ctrlWord;

  fpuErrSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(ignoreErrAsync), .syncOut(ignSync)
  );

  fpuErrCtrl u_ctrl (
    .nativeEn(nativeEn), .ignSync(ignSync), .errStrobe(errStrobe),
    .errClear(errClear), .issueValid(issueValid),
    .issueWaitClass(issueWaitClass), .nativePend(nativePend),
    .legacyPend(legacyPend), .stb(stb), .nativeExcReq(nativeExcReq),
    .issueStall(issueStall)
  );

  fpuErrDp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .nativePend(nativePend),
    .legacyPend(legacyPend), .errPinN(errPinN)
  );

  // R5
  stall_needs_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueStall |-> (!errPinN && issueValid && issueWaitClass));
  // R2
  exc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nativeExcReq && !errStrobe) |=> !nativeExcReq);
  // R4
  pin_assert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errStrobe && !nativeEn && !ignSync) |=> !errPinN);
  // R3
  ignored_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errPinN && errStrobe && !nativeEn && ignSync) |=> errPinN);
  // R6
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!errPinN && !errClear) |=> !errPinN);
  // R6
  pin_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errClear && !errStrobe) |=> errPinN);
  // R2
  native_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errPinN && errStrobe && nativeEn) |=> (errPinN && !issueStall));
endmodule

// File: tb/sim_fpuErrReport.sv
module sim_fpuErrReport;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic        ignoreErrAsync = 1'b0;
  logic        errStrobe = 1'b0;
  logic        errClear = 1'b0;
  logic        issueValid = 1'b0;
  logic        issueWaitClass = 1'b0;
  logic        nativeExcReq, errPinN, issueStall;

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";

  bit mdNat = 0, mdLeg = 0;
  bit ignHist[$] = '{0, 0};

  always #2 clk = ~clk;

  fpuErrReport u0 (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .ignoreErrAsync(ignoreErrAsync), .errStrobe(errStrobe),
    .errClear(errClear), .issueValid(issueValid),
    .issueWaitClass(issueWaitClass), .nativeExcReq(nativeExcReq),
    .errPinN(errPinN), .issueStall(issueStall)
  );

  // Behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    bit ne, ignUsed, doWait, nNat, nLeg;
    if (!rstN) begin
      mdNat = 0; mdLeg = 0; ignHist = '{0, 0};
    end else begin
      ne      = ctrlWord[5];
      ignUsed = ignHist[0];
      doWait  = issueValid && issueWaitClass;
      nNat = mdNat; nLeg = mdLeg;
      if (errClear || (mdNat && doWait)) nNat = 0;
      if (errClear) nLeg = 0;
      if (errStrobe && ne) nNat = 1;
      if (errStrobe && !ne && !ignUsed) nLeg = 1;
      mdNat = nNat; mdLeg = nLeg;
      ignHist.push_back(ignoreErrAsync);
      void'(ignHist.pop_front());
    end
  end

  task automatic chk(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    bit doWait;
    doWait = issueValid && issueWaitClass;
    chk("errPinN", errPinN, !mdLeg);
    chk("issueStall", issueStall, mdLeg && doWait);
    chk("nativeExcReq", nativeExcReq, mdNat && doWait);
  end

  task automatic cyc(bit strb, bit clr, bit iv, bit wc);
    errStrobe = strb; errClear = clr; issueValid = iv; issueWaitClass = wc;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset values
    curReq = "R1";
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(2);

    // R2: native report, one request at the first waiting issue
    curReq = "R2";
    ctrlWord = 32'h20;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 1);
    cyc(0, 0, 1, 1);
    idle(2);
    // R8: native request and new strobe on the same edge keep it pending
    curReq = "R8";
    cyc(1, 0, 0, 0);
    cyc(1, 0, 1, 1);
    cyc(0, 0, 1, 1);
    idle(2);

    // R9: clear discards a native error
    curReq = "R9";
    cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 1);
    idle(2);

    // R10: every bit but bit 5 set selects legacy mode
    curReq = "R10";
    ctrlWord = 32'hFFFF_FFDF;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 1);
    cyc(0, 1, 0, 0);
    ctrlWord = 32'h0000_0020;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 1);
    idle(2);

    // R4/R5: legacy report and selective stall
    curReq = "R4";
    ctrlWord = 32'h0;
    cyc(1, 0, 0, 0);
    curReq = "R5";
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 1, 1);
    // R6: pin held until clear
    curReq = "R6";
    idle(4);
    cyc(0, 1, 1, 1);
    cyc(0, 0, 1, 1);
    idle(1);

    // R8: strobe and clear at the same edge
    curReq = "R8";
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);
    cyc(0, 0, 1, 1);
    cyc(0, 1, 0, 0);
    idle(1);

    // R3: ignore asserted and settled
    curReq = "R3";
    ignoreErrAsync = 1'b1;
    idle(3);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 1);
    idle(1);

    // R7: strobe one edge after ignore falls is still ignored
    curReq = "R7";
    ignoreErrAsync = 1'b0;
    cyc(0, 0, 0, 0);
    cyc(1, 0, 1, 1);
    cyc(0, 0, 1, 1);
    idle(2);
    // ignore rises, strobe one edge later is still reported
    ignoreErrAsync = 1'b1;
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 1);
    cyc(0, 1, 0, 0);
    idle(2);

    // R5: random stretch including collisions
    curReq = "R5";
    for (int i = 0; i < 2000; i++) begin
      ctrlWord = $urandom;
      ignoreErrAsync = $urandom_range(0, 1);
      cyc($urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
          $urandom_range(0, 1), $urandom_range(0, 1));
    end
    idle(2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule